// File: doc/BRIEF.md
# Substrate Electronic Shutter Controller

This block sets the exposure of an interline image sensor. It does so by placing one shutter-enable pulse, which empties every photodiode through the substrate, inside a chosen horizontal retrace window of the frame. Integration then runs from the end of that pulse to the frame transfer that follows. The requested exposure is a count of lines written through a simple request strobe. The readout sequencer supplies three things: a strobe at the start of each retrace window, the length of that window and of the next one in clock cycles, and a strobe at each frame transfer. The high-voltage driver outside the block turns `shutterEn` into the actual substrate pulse.

Within a frame, retrace windows are numbered from 0, where window 0 is the first retrace after a frame transfer. For an exposure of `n` lines the pulse goes into window `LINES - n`, so `n` line periods remain before the next transfer. A request takes effect only at a frame transfer. The status outputs report the exposure currently in force and whether the latest request has been adopted. The pulse is never cut short. If the chosen window cannot hold the guard delay plus the full pulse, the pulse moves one window earlier.

Top module: `shutter_ctrl`

## Requirements
- R1: During and right after reset, `shutterEn` is 0, `appliedLines` equals `LINES` (shutter off) and `settingApplied` is 1.
- R2: With an exposure of `n` lines in force (MIN_LINES <= n < LINES), the pulse is issued in retrace window `LINES - n` of the frame, where window 0 is the first retrace after the frame transfer.
- R3: `shutterEn` rises `GUARD_CYC` clock cycles after the clock edge that samples `retraceStart`, stays high for exactly `WIDTH_CYC` cycles, and lies wholly inside the window of `winCycles` cycles.
- R4: A request of `LINES` or more turns the shutter off: `appliedLines` reads `LINES` and no pulse is issued in that frame.
- R5: A request below `MIN_LINES`, including 0, is raised to `MIN_LINES`, and the pulse goes into window `LINES - MIN_LINES`.
- R6: A request written during a frame has no effect on that frame. `appliedLines` and the pulse placement change only at the next `frameXfer`.
- R7: `settingApplied` reads 0 in the cycle after a request strobe. It returns to 1 in the cycle after the `frameXfer` that adopts the request.
- R8: If the target window is shorter than `GUARD_CYC + WIDTH_CYC` cycles, the pulse is issued in the window just before it (the block learns this through `nextWinCycles`). If that earlier window is too short as well, no pulse is issued in that frame.
- R9: At most one pulse is issued between two frame transfers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | One-cycle strobe: record `reqLines` as the pending exposure |
| reqLines | input | $clog2(LINES+1) | Requested exposure in lines |
| frameXfer | input | 1 | One-cycle strobe at the photodiode-to-vertical transfer (frame boundary) |
| retraceStart | input | 1 | One-cycle strobe at the start of a horizontal retrace window |
| winCycles | input | WIN_W | Length in cycles of the window that starts now |
| nextWinCycles | input | WIN_W | Length in cycles of the following window |
| shutterEn | output | 1 | Shutter pulse request to the substrate driver |
| appliedLines | output | $clog2(LINES+1) | Exposure in force, in lines; `LINES` means shutter off |
| settingApplied | output | 1 | 1 when the latest request has been adopted |

## Verification
The assertions assume the following about the sequencer. `frameXfer` never arrives while a pulse is in progress. `retraceStart` comes once per line and never while a pulse is running. `winCycles` and `nextWinCycles` give the true window lengths. The bench honours all of this. It drives exactly `LINES` retrace windows per frame and issues the transfer only after the last window and its readout gap have closed. It also derives each `nextWinCycles` from the same length table it uses to size the following window. Within these limits the directed frames cover these cases: shutter off, an exposure requested mid-frame, clamping at both ends, and a short window that forces the pulse one window earlier. The earliest-target case is covered too.

// File: rtl/shutter_pkg.sv
package shutter_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // record a new request as pending
    logic adopt;    // frame boundary: pending becomes active
  } shtStrobe_t;
endpackage

// File: rtl/shutter_dp.sv
module shutter_dp
  import shutter_pkg::*;
#(
  parameter int LINES     = 1024,
  parameter int MIN_LINES = 2,
  localparam int LW = $clog2(LINES + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  shtStrobe_t    strb,
  input  logic [LW-1:0] reqLines,
  output logic [LW-1:0] targetIdx,
  output logic          shutterOff,
  output logic [LW-1:0] appliedLines,
  output logic          settingApplied
);
  localparam logic [LW-1:0] LINES_V = LW'(LINES);
  localparam logic [LW-1:0] MIN_V   = LW'(MIN_LINES);

  logic [LW-1:0] pendLines;
  logic [LW-1:0] activeLines;
  logic [LW-1:0] pendClamped;

  always_comb begin
    if (pendLines >= LINES_V)    pendClamped = LINES_V;
    else if (pendLines < MIN_V)  pendClamped = MIN_V;
    else                         pendClamped = pendLines;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendLines      <= LINES_V;
      activeLines    <= LINES_V;
      settingApplied <= 1'b1;
    end else begin
      if (strb.adopt)   activeLines <= pendClamped;
      if (strb.capture) pendLines   <= reqLines;
      if (strb.capture)    settingApplied <= 1'b0;
      else if (strb.adopt) settingApplied <= 1'b1;
    end
  end

  assign appliedLines = activeLines;
  assign shutterOff   = (activeLines == LINES_V);
  assign targetIdx    = LINES_V - activeLines;

  // R5 / R4: status always within the clamp range
  assert_applied_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    (appliedLines >= MIN_V) && (appliedLines <= LINES_V));

  // R6: exposure in force changes only at a frame boundary
  assert_change_at_boundary_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.adopt) |-> $stable(appliedLines));

  // R7: flag returns only after an adopting boundary
  assert_flag_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(settingApplied) |-> $past(strb.adopt));
endmodule

// File: rtl/shutter_ctl.sv
module shutter_ctl
  import shutter_pkg::*;
#(
  parameter int LINES     = 1024,
  parameter int GUARD_CYC = 50,
  parameter int WIDTH_CYC = 1250,
  parameter int WIN_W     = 12,
  localparam int LW = $clog2(LINES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             frameXfer,
  input  logic             retraceStart,
  input  logic [WIN_W-1:0] winCycles,
  input  logic [WIN_W-1:0] nextWinCycles,
  input  logic [LW-1:0]    targetIdx,
  input  logic             shutterOff,
  output shtStrobe_t       strb,
  output logic             shutterEn
);
  localparam int SPAN  = GUARD_CYC + WIDTH_CYC;
  localparam int CMAX  = (GUARD_CYC > WIDTH_CYC) ? GUARD_CYC : WIDTH_CYC;
  localparam int CNT_W = $clog2(CMAX + 1);
  localparam logic [WIN_W:0] SPAN_V  = (WIN_W+1)'(SPAN);
  localparam logic [LW-1:0]  LINES_V = LW'(LINES);

  typedef enum logic [1:0] {ST_IDLE, ST_GUARD, ST_HIGH} shtState_t;

  shtState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [LW-1:0]    lineIdx;
  logic             shotDone;
  logic             fitsCur, fitsNext, hitTarget, hitPrev, fire;

  always_comb begin
    strb.capture = reqValid;
    strb.adopt   = frameXfer;
  end

  assign fitsCur   = {1'b0, winCycles}     >= SPAN_V;
  assign fitsNext  = {1'b0, nextWinCycles} >= SPAN_V;
  assign hitTarget = (lineIdx == targetIdx);
  assign hitPrev   = (lineIdx == targetIdx - LW'(1));
  assign fire = retraceStart && !frameXfer && !shutterOff && !shotDone &&
                (state == ST_IDLE) && fitsCur &&
                (hitTarget || (hitPrev && !fitsNext));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineIdx  <= '0;
      shotDone <= 1'b0;
    end else if (frameXfer) begin
      lineIdx  <= '0;
      shotDone <= 1'b0;
    end else begin
      if (retraceStart && lineIdx != LINES_V) lineIdx <= lineIdx + LW'(1);
      if (fire) shotDone <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (fire) begin
          state <= ST_GUARD;
          cnt   <= '0;
        end
        ST_GUARD: if (cnt == CNT_W'(GUARD_CYC - 1)) begin
          state <= ST_HIGH;
          cnt   <= '0;
        end else cnt <= cnt + CNT_W'(1);
        ST_HIGH: if (cnt == CNT_W'(WIDTH_CYC - 1)) begin
          state <= ST_IDLE;
          cnt   <= '0;
        end else cnt <= cnt + CNT_W'(1);
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign shutterEn = (state == ST_HIGH);

  // ---- checker state for the assertions below ----
  localparam int HR_W = $clog2(WIDTH_CYC + 2);
  logic [WIN_W:0]   sinceRet;
  logic [WIN_W-1:0] winHeld;
  logic [HR_W-1:0]  highRun;
  logic [1:0]       risesInFrame;
  logic             prevEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceRet     <= '1;
      winHeld      <= '0;
      highRun      <= '0;
      risesInFrame <= '0;
      prevEn       <= 1'b0;
    end else begin
      if (retraceStart) begin
        sinceRet <= '0;
        winHeld  <= winCycles;
      end else if (sinceRet != '1) sinceRet <= sinceRet + 1'b1;
      highRun <= shutterEn ? highRun + HR_W'(1) : '0;
      prevEn  <= shutterEn;
      if (frameXfer) risesInFrame <= '0;
      else if (shutterEn && !prevEn && risesInFrame != 2'd3)
        risesInFrame <= risesInFrame + 2'd1;
    end
  end

  // R3: pulse lies inside the current retrace window
  assert_pulse_in_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    shutterEn |-> (sinceRet < {1'b0, winHeld}));

  // R3: pulse is never truncated nor stretched
  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(shutterEn) |-> (highRun == HR_W'(WIDTH_CYC)));

  // R9: one pulse per frame
  assert_one_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shutterEn) |-> (risesInFrame == 2'd0));

  // R4: no pulse while the shutter is off
  assert_off_no_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    shutterOff |-> !shutterEn);
endmodule

// File: rtl/shutter_ctrl.sv
module shutter_ctrl
  import shutter_pkg::*;
#(
  parameter int LINES     = 1024,
  parameter int MIN_LINES = 2,
  parameter int GUARD_CYC = 50,
  parameter int WIDTH_CYC = 1250,
  parameter int WIN_W     = 12,
  localparam int LW = $clog2(LINES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [LW-1:0]    reqLines,
  input  logic             frameXfer,
  input  logic             retraceStart,
  input  logic [WIN_W-1:0] winCycles,
  input  logic [WIN_W-1:0] nextWinCycles,
  output logic             shutterEn,
  output logic [LW-1:0]    appliedLines,
  output logic             settingApplied
);
  shtStrobe_t    strb;
  logic [LW-1:0] targetIdx;
  logic          shutterOff;

  shutter_ctl #(
    .LINES(LINES), .GUARD_CYC(GUARD_CYC), .WIDTH_CYC(WIDTH_CYC), .WIN_W(WIN_W)
  ) i_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .frameXfer(frameXfer),
    .retraceStart(retraceStart), .winCycles(winCycles),
    .nextWinCycles(nextWinCycles), .targetIdx(targetIdx),
    .shutterOff(shutterOff), .strb(strb), .shutterEn(shutterEn)
  );

  shutter_dp #(.LINES(LINES), .MIN_LINES(MIN_LINES)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqLines(reqLines),
    .targetIdx(targetIdx), .shutterOff(shutterOff),
    .appliedLines(appliedLines), .settingApplied(settingApplied)
  );
endmodule

// File: tb/test_shutter_ctrl.sv
`timescale 1ns/1ps
module test_shutter_ctrl;
  localparam int LINES = 16, MIN_LINES = 2, G = 2, W = 5, WIN_W = 6;
  localparam int LW = $clog2(LINES + 1);
  localparam int LONG_WIN = 10, SHORT_WIN = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, frameXfer = 1'b0, retraceStart = 1'b0;
  logic [LW-1:0] reqLines = '0;
  logic [WIN_W-1:0] winCycles = '0, nextWinCycles = '0;
  logic shutterEn, settingApplied;
  logic [LW-1:0] appliedLines;

  int checks = 0, errors = 0;
  bit done = 0;

  shutter_ctrl #(.LINES(LINES), .MIN_LINES(MIN_LINES), .GUARD_CYC(G),
                 .WIDTH_CYC(W), .WIN_W(WIN_W)) i_shutter_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLines(reqLines),
    .frameXfer(frameXfer), .retraceStart(retraceStart), .winCycles(winCycles),
    .nextWinCycles(nextWinCycles), .shutterEn(shutterEn),
    .appliedLines(appliedLines), .settingApplied(settingApplied));

  always #10 clk = ~clk;

  task automatic checkEq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic doXfer();
    frameXfer = 1'b1; cyc(); frameXfer = 1'b0;
  endtask

  task automatic writeReq(int v);
    reqValid = 1'b1; reqLines = LW'(v); cyc(); reqValid = 1'b0;
  endtask

  // One frame: transfer, then LINES retrace windows with readout gaps.
  // Optional request write before window writeAt.
  task automatic runFrame(input int shortLine, input int writeAt, input int writeVal,
                          output int pulseLine, output int highTotal,
                          output int firstJ, output int pulseLines);
    int lastLine;
    pulseLine = -1; highTotal = 0; firstJ = -1; pulseLines = 0; lastLine = -1;
    doXfer();
    for (int k = 0; k < LINES; k++) begin
      int len;
      len = (k == shortLine) ? SHORT_WIN : LONG_WIN;
      if (k == writeAt) writeReq(writeVal);
      retraceStart  = 1'b1;
      winCycles     = WIN_W'(len);
      nextWinCycles = WIN_W'((k + 1 == shortLine) ? SHORT_WIN : LONG_WIN);
      cyc();
      retraceStart = 1'b0;
      for (int j = 0; j < len + 3; j++) begin
        if (j > 0) cyc();
        if (shutterEn) begin
          highTotal++;
          if (pulseLine < 0) begin pulseLine = k; firstJ = j; end
          if (lastLine != k) begin pulseLines++; lastLine = k; end
        end
      end
    end
  endtask

  task automatic testReset();
    checkEq("R1 shutterEn after reset", int'(shutterEn), 0);
    checkEq("R1 appliedLines after reset", int'(appliedLines), LINES);
    checkEq("R1 settingApplied after reset", int'(settingApplied), 1);
  endtask

  task automatic testOffFrame();
    int pl, ht, fj, pn;
    runFrame(-1, -1, 0, pl, ht, fj, pn);
    checkEq("R4 no pulse when off", ht, 0);
  endtask

  task automatic testDeferred();
    int pl, ht, fj, pn;
    runFrame(-1, 3, 5, pl, ht, fj, pn);
    checkEq("R6 frame in progress unaffected", ht, 0);
    checkEq("R6 appliedLines unchanged before boundary", int'(appliedLines), LINES);
    checkEq("R7 flag low while pending", int'(settingApplied), 0);
    runFrame(-1, -1, 0, pl, ht, fj, pn);
    checkEq("R6 appliedLines after boundary", int'(appliedLines), 5);
    checkEq("R7 flag high after adopt", int'(settingApplied), 1);
    checkEq("R2 pulse window for 5 lines", pl, LINES - 5);
    checkEq("R3 guard delay", fj, G);
    checkEq("R3 pulse width", ht, W);
    checkEq("R9 single pulse per frame", pn, 1);
  endtask

  task automatic testClampHigh();
    int pl, ht, fj, pn;
    writeReq(20);
    runFrame(-1, -1, 0, pl, ht, fj, pn);
    checkEq("R4 request above frame -> off", int'(appliedLines), LINES);
    checkEq("R4 no pulse for oversize request", ht, 0);
    writeReq(LINES);
    runFrame(-1, -1, 0, pl, ht, fj, pn);
    checkEq("R4 request equal frame -> off", int'(appliedLines), LINES);
    checkEq("R4 no pulse for full-frame request", ht, 0);
  endtask

  task automatic testClampLow();
    int pl, ht, fj, pn;
    writeReq(0);
    runFrame(-1, -1, 0, pl, ht, fj, pn);
    checkEq("R5 zero request clamped", int'(appliedLines), MIN_LINES);
    checkEq("R5 pulse window at minimum", pl, LINES - MIN_LINES);
    writeReq(1);
    runFrame(-1, -1, 0, pl, ht, fj, pn);
    checkEq("R5 one-line request clamped", int'(appliedLines), MIN_LINES);
    checkEq("R5 pulse width at minimum", ht, W);
  endtask

  task automatic testShortWindow();
    int pl, ht, fj, pn;
    writeReq(5);
    runFrame(LINES - 5, -1, 0, pl, ht, fj, pn);
    checkEq("R8 pulse moved to earlier window", pl, LINES - 6);
    checkEq("R8 moved pulse not truncated", ht, W);
    checkEq("R8 moved pulse guard delay", fj, G);
    writeReq(15);
    runFrame(-1, -1, 0, pl, ht, fj, pn);
    checkEq("R2 earliest target window", pl, 1);
    runFrame(1, -1, 0, pl, ht, fj, pn);
    checkEq("R8 earliest target moved to window 0", pl, 0);
    checkEq("R9 one pulse with moved target", pn, 1);
  endtask

  initial begin
    repeat (3) cyc();
    testReset();
    rstN = 1'b1;
    cyc();
    testReset();
    testOffFrame();
    testDeferred();
    testClampHigh();
    testClampLow();
    testShortWindow();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule